// File: doc/BRIEF.md
# Processor-to-Memory Crosspoint Switch

This block joins a set of requesting processor ports to a larger set of memory module ports through a full crosspoint. Any requester can reach any memory. The upper bits of the requester's address pick the memory. Each connection carries the complete address, the write word and a write strobe toward the memory. A separate set of lines brings the read word back to the requester. Requesters that target different memories are connected in the same cycle and transfer side by side.

Each memory port has its own allocator. When two or more requesters want the same free memory in one cycle, the lowest-numbered requester wins. The others keep their requests raised and wait. When a memory accepts a requester, that pairing is fixed until the memory acknowledges. The crosspoint is released in the acknowledge cycle, so the next waiting requester is connected on the following cycle with no idle gap.

Both sides use a valid/ready handshake. On the requester side, `req_valid` must stay high with stable address, write word and strobe until `req_ready` is seen high. `req_ready` marks completion, and `rsp_rdata` is valid in that same cycle. On the memory side, `mem_valid` stays high with stable fields until the memory raises `mem_ready`. A memory may hold `mem_ready` high permanently to complete every access in one cycle. A memory that holds `mem_ready` low stalls only its own connection.

Top module: `mem_crosspoint`

## Requirements
- R1: A request is routed to the memory numbered by the top `$clog2(N_MEM)` bits of `req_addr` (bits 15:12 with defaults), for every requester and every memory number.
- R2: While a memory port shows `mem_valid`, its `mem_addr`, `mem_wdata` and `mem_we` equal the connected requester's `req_addr`, `req_wdata` and `req_we`.
- R3: When a memory is free and several requesters target it in the same cycle, the lowest-numbered requester is connected.
- R4: A requester that loses keeps `req_valid` high, sees `req_ready` low, and is served in a later cycle without reissuing.
- R5: Once a memory has been connected to a requester and `mem_ready` is low, the same requester stays connected in the next cycle, even if a lower-numbered requester now targets that memory.
- R6: In the cycle a connected memory raises `mem_ready`, the owner's `req_ready` is high in that same cycle. The memory can be connected to another waiting requester in the very next cycle.
- R7: Requesters that target distinct memories are all connected, and all complete, in the same cycle.
- R8: Each memory port is connected to at most one requester per cycle. A memory with no requester shows `mem_valid` low. After reset, with no requests, all `mem_valid` and `req_ready` are low.
- R9: In the completing cycle, `rsp_rdata` of the owner equals `mem_rdata` of the memory it was connected to.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | N_REQ | Request present, one per requester |
| req_ready | output | N_REQ | Access completed this cycle, one per requester |
| req_addr | input | N_REQ x ADDR_W | Address; top bits select the memory |
| req_we | input | N_REQ | Write strobe |
| req_wdata | input | N_REQ x DATA_W | Write word |
| rsp_rdata | output | N_REQ x DATA_W | Read word returned to requester |
| mem_valid | output | N_MEM | Memory port has a connected requester |
| mem_ready | input | N_MEM | Memory acknowledge |
| mem_addr | output | N_MEM x ADDR_W | Address forwarded to the memory |
| mem_we | output | N_MEM | Write strobe forwarded to the memory |
| mem_wdata | output | N_MEM x DATA_W | Write word forwarded to the memory |
| mem_rdata | input | N_MEM x DATA_W | Read word from the memory |

## Verification
The switch is driven with four patterns, each aimed at a different failure.
- **All requesters on one memory.** With an always-ready memory, the completion order exposes any wrong priority or any idle cycle after release.
- **Distinct targets.** Four requesters on four different memories show whether the paths really run concurrently.
- **Late high-priority request.** A stalled memory is held by a low-priority owner while a higher-priority request arrives. This separates a held connection from one that is preempted.
- **Sweep and random traffic.** A sweep moves every requester across every memory number. Long random traffic with random acknowledges is then compared every cycle against a behavioural model. Together they catch wrong select decoding, swapped fields on either path, and double connections.

// File: rtl/xp_pkg.sv
package xp_pkg;
  typedef enum logic {
    SLOT_FREE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_e;
endpackage

// File: rtl/xp_alloc.sv
module xp_alloc
  import xp_pkg::*;
#(
  parameter int N_REQ = 4,
  parameter int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] hit,
  input  logic             mem_ready,
  output logic             active,
  output logic [IDX_W-1:0] owner,
  output logic [N_REQ-1:0] gnt
);
  slot_e            state_q;
  logic [IDX_W-1:0] owner_q;
  logic [IDX_W-1:0] pick;

  // lowest index wins among the requesters aimed at this memory
  always_comb begin
    pick = '0;
    for (int k = N_REQ - 1; k >= 0; k--) begin
      if (hit[k]) pick = IDX_W'(k);
    end
  end

  assign active = (state_q == SLOT_HELD) || (|hit);
  assign owner  = (state_q == SLOT_HELD) ? owner_q : pick;

  always_comb begin
    for (int k = 0; k < N_REQ; k++) begin
      gnt[k] = active && (owner == IDX_W'(k));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
      owner_q <= '0;
    end else if (active && !mem_ready) begin
      state_q <= SLOT_HELD;
      owner_q <= owner;
    end else begin
      state_q <= SLOT_FREE;
    end
  end

  p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_grant_targets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> (|(gnt & hit)));

  p_lock_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mem_ready) |=> (active && owner == $past(owner)));

  p_top_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_FREE && hit[0]) |-> gnt[0]);

  p_holder_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_HELD) |-> hit[owner_q]);
endmodule

// File: rtl/xp_fwd.sv
module xp_fwd #(
  parameter int N_REQ  = 4,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                         active,
  input  logic [IDX_W-1:0]             owner,
  input  logic [N_REQ-1:0][ADDR_W-1:0] req_addr,
  input  logic [N_REQ-1:0]             req_we,
  input  logic [N_REQ-1:0][DATA_W-1:0] req_wdata,
  output logic                         mem_valid,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         mem_we,
  output logic [DATA_W-1:0]            mem_wdata
);
  always_comb begin
    mem_valid = active;
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    if (active) begin
      mem_addr  = req_addr[owner];
      mem_we    = req_we[owner];
      mem_wdata = req_wdata[owner];
    end
  end
endmodule

// File: rtl/xp_ret.sv
module xp_ret #(
  parameter int N_MEM  = 16,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [SEL_W-1:0]             tgt,
  input  logic [N_MEM-1:0]             gcol,
  input  logic [N_MEM-1:0]             mem_ready,
  input  logic [N_MEM-1:0][DATA_W-1:0] mem_rdata,
  output logic                         req_ready,
  output logic [DATA_W-1:0]            rsp_rdata
);
  assign req_ready = |(gcol & mem_ready);
  assign rsp_rdata = mem_rdata[tgt];

  p_one_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gcol));

  p_done_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  p_path_matches_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|gcol) |-> gcol[tgt]);
endmodule

// File: rtl/mem_crosspoint.sv
module mem_crosspoint #(
  parameter int N_REQ  = 4,
  parameter int N_MEM  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_REQ-1:0]             req_valid,
  output logic [N_REQ-1:0]             req_ready,
  input  logic [N_REQ-1:0][ADDR_W-1:0] req_addr,
  input  logic [N_REQ-1:0]             req_we,
  input  logic [N_REQ-1:0][DATA_W-1:0] req_wdata,
  output logic [N_REQ-1:0][DATA_W-1:0] rsp_rdata,
  output logic [N_MEM-1:0]             mem_valid,
  input  logic [N_MEM-1:0]             mem_ready,
  output logic [N_MEM-1:0][ADDR_W-1:0] mem_addr,
  output logic [N_MEM-1:0]             mem_we,
  output logic [N_MEM-1:0][DATA_W-1:0] mem_wdata,
  input  logic [N_MEM-1:0][DATA_W-1:0] mem_rdata
);
  localparam int SEL_W = (N_MEM > 1) ? $clog2(N_MEM) : 1;
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_REQ-1:0][SEL_W-1:0] tgt;
  logic [N_MEM-1:0][N_REQ-1:0] hit;
  logic [N_MEM-1:0][N_REQ-1:0] gnt;
  logic [N_REQ-1:0][N_MEM-1:0] gcol;
  logic [N_MEM-1:0]            active;
  logic [N_MEM-1:0][IDX_W-1:0] owner;

  for (genvar i = 0; i < N_REQ; i++) begin : g_dec
    assign tgt[i] = req_addr[i][ADDR_W-1 -: SEL_W];
    for (genvar j = 0; j < N_MEM; j++) begin : g_cross
      assign hit[j][i]  = req_valid[i] && (tgt[i] == SEL_W'(j));
      assign gcol[i][j] = gnt[j][i];
    end
  end

  for (genvar j = 0; j < N_MEM; j++) begin : g_mem
    xp_alloc #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit[j]),
      .mem_ready (mem_ready[j]),
      .active    (active[j]),
      .owner     (owner[j]),
      .gnt       (gnt[j])
    );
    xp_fwd #(.N_REQ(N_REQ), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
      .active    (active[j]),
      .owner     (owner[j]),
      .req_addr  (req_addr),
      .req_we    (req_we),
      .req_wdata (req_wdata),
      .mem_valid (mem_valid[j]),
      .mem_addr  (mem_addr[j]),
      .mem_we    (mem_we[j]),
      .mem_wdata (mem_wdata[j])
    );
  end

  for (genvar i = 0; i < N_REQ; i++) begin : g_req
    xp_ret #(.N_MEM(N_MEM), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_ret (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[i]),
      .tgt       (tgt[i]),
      .gcol      (gcol[i]),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .req_ready (req_ready[i]),
      .rsp_rdata (rsp_rdata[i])
    );
  end

  // a requester holding a stalled memory must not show completion
  p_no_early_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid[0] && !mem_ready[0]) |-> !(|(req_ready & gnt[0])));

  p_idle_mem_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid == '0) |-> (mem_valid == '0) || $past(mem_valid != '0));
endmodule

// File: tb/mem_crosspoint_tb_top.sv
`timescale 1ns/1ps
module mem_crosspoint_tb_top;
  localparam int N_REQ  = 4;
  localparam int N_MEM  = 16;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N_REQ-1:0]             req_valid = '0;
  logic [N_REQ-1:0]             req_ready;
  logic [N_REQ-1:0][ADDR_W-1:0] req_addr = '0;
  logic [N_REQ-1:0]             req_we = '0;
  logic [N_REQ-1:0][DATA_W-1:0] req_wdata = '0;
  logic [N_REQ-1:0][DATA_W-1:0] rsp_rdata;
  logic [N_MEM-1:0]             mem_valid;
  logic [N_MEM-1:0]             mem_ready = '0;
  logic [N_MEM-1:0][ADDR_W-1:0] mem_addr;
  logic [N_MEM-1:0]             mem_we;
  logic [N_MEM-1:0][DATA_W-1:0] mem_wdata;
  logic [N_MEM-1:0][DATA_W-1:0] mem_rdata = '0;

  mem_crosspoint #(.N_REQ(N_REQ), .N_MEM(N_MEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // bench-side requester queue (one outstanding item each) and memory behaviour
  bit              p_val [N_REQ];
  logic [ADDR_W-1:0] p_addr [N_REQ];
  logic              p_we [N_REQ];
  logic [DATA_W-1:0] p_wd [N_REQ];
  logic [N_MEM-1:0]  mrdy = '0;
  int                done_cyc [N_REQ];
  // reference model state
  bit m_busy [N_MEM];
  int m_who  [N_MEM];
  logic [31:0] rs = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic cycle();
    int own;
    bit er [N_REQ];
    logic [DATA_W-1:0] erd [N_REQ];
    for (int i = 0; i < N_REQ; i++) begin
      req_valid[i] = p_val[i];
      req_addr[i]  = p_addr[i];
      req_we[i]    = p_we[i];
      req_wdata[i] = p_wd[i];
      er[i] = 1'b0;
      erd[i] = '0;
    end
    mem_ready = mrdy;
    for (int j = 0; j < N_MEM; j++) mem_rdata[j] = (32'(j) << 24) ^ (32'(cyc) * 32'd977);
    #2;
    for (int j = 0; j < N_MEM; j++) begin
      own = -1;
      if (m_busy[j]) own = m_who[j];
      else begin
        for (int i = N_REQ - 1; i >= 0; i--)
          if (p_val[i] && p_addr[i][ADDR_W-1 -: SEL_W] == SEL_W'(j)) own = i;
      end
      chk(mem_valid[j] == (own >= 0), "R8", "mem_valid", longint'(mem_valid[j]), longint'(own >= 0));
      if (own >= 0) begin
        chk(mem_addr[j] == p_addr[own], "R2", "mem_addr", longint'(mem_addr[j]), longint'(p_addr[own]));
        chk(mem_wdata[j] == p_wd[own], "R2", "mem_wdata", longint'(mem_wdata[j]), longint'(p_wd[own]));
        chk(mem_we[j] == p_we[own], "R2", "mem_we", longint'(mem_we[j]), longint'(p_we[own]));
        if (mrdy[j]) begin
          er[own] = 1'b1;
          erd[own] = mem_rdata[j];
        end
      end
      m_busy[j] = (own >= 0) && !mrdy[j];
      m_who[j]  = own;
    end
    for (int i = 0; i < N_REQ; i++) begin
      chk(req_ready[i] == er[i], "R6", "req_ready", longint'(req_ready[i]), longint'(er[i]));
      if (er[i]) begin
        chk(rsp_rdata[i] == erd[i], "R9", "rsp_rdata", longint'(rsp_rdata[i]), longint'(erd[i]));
        p_val[i] = 1'b0;
        done_cyc[i] = cyc;
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic issue(input int i, input int mem, input logic we);
    p_val[i]  = 1'b1;
    p_addr[i] = {SEL_W'(mem), 12'(rnd())};
    p_we[i]   = we;
    p_wd[i]   = rnd();
  endtask

  task automatic drain();
    int guard = 0;
    mrdy = '1;
    while ((p_val[0] || p_val[1] || p_val[2] || p_val[3]) && guard < 100) begin
      cycle();
      guard++;
    end
    chk(guard < 100, "R4", "drain completes", longint'(guard), 0);
  endtask

  initial begin
    int base;
    for (int i = 0; i < N_REQ; i++) begin p_val[i] = 0; p_addr[i] = '0; p_we[i] = 0; p_wd[i] = '0; done_cyc[i] = -1; end
    for (int j = 0; j < N_MEM; j++) begin m_busy[j] = 0; m_who[j] = -1; end
    @(negedge clk);
    // R8: reset state
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(mem_valid == '0, "R8", "reset mem_valid", longint'(mem_valid), 0);
      chk(req_ready == '0, "R8", "reset req_ready", longint'(req_ready), 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R4 / R6: all requesters on memory 5, always-ready memory
    mrdy = '1;
    for (int i = 0; i < N_REQ; i++) issue(i, 5, i[0]);
    base = cyc;
    drain();
    for (int i = 0; i < N_REQ; i++)
      chk(done_cyc[i] == base + i, "R3", "priority completion cycle", longint'(done_cyc[i]), longint'(base + i));

    // R7: distinct memories complete together
    for (int i = 0; i < N_REQ; i++) issue(i, 4 * i + 1, 1'b1);
    base = cyc;
    drain();
    for (int i = 0; i < N_REQ; i++)
      chk(done_cyc[i] == base, "R7", "concurrent completion", longint'(done_cyc[i]), longint'(base));

    // R5: low-priority owner keeps a stalled memory against a later higher one
    mrdy = '0;
    issue(3, 2, 1'b0);
    cycle();
    issue(0, 2, 1'b1);
    for (int k = 0; k < 3; k++) begin
      cycle();
      chk(mem_addr[2] == p_addr[3], "R5", "held owner address", longint'(mem_addr[2]), longint'(p_addr[3]));
    end
    drain();
    chk(done_cyc[0] == done_cyc[3] + 1, "R5", "late high priority served next",
        longint'(done_cyc[0]), longint'(done_cyc[3] + 1));

    // R1 / R9: sweep every requester over every memory number
    for (int s = 0; s < N_MEM; s++) begin
      for (int i = 0; i < N_REQ; i++) issue(i, (s + 4 * i) % N_MEM, 1'b0);
      base = cyc;
      drain();
      for (int i = 0; i < N_REQ; i++)
        chk(done_cyc[i] == base, "R1", "sweep routed", longint'(done_cyc[i]), longint'(base));
    end

    // random traffic with random acknowledges, checked every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N_REQ; i++) begin
        if (!p_val[i] && rnd()[0]) issue(i, (rnd()[2]) ? int'(rnd() % 16) : int'(rnd() % 3), rnd()[1]);
      end
      for (int j = 0; j < N_MEM; j++) mrdy[j] = (rnd() % 8) < 5;
      cycle();
    end
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule